// File: doc/BRIEF.md
# Pin-Controlled Nonvolatile Store/Recall Controller

This block sequences a shadowed SRAM, where every SRAM cell has a nonvolatile twin. It samples four active-low control pins: chip enable, output enable, write enable and nonvolatile enable. From them it decodes a mode: deselected, SRAM read, SRAM write, STORE (SRAM copied into the nonvolatile array), RECALL (nonvolatile array copied into the SRAM) or no operation. The pins are assumed to be already synchronised to the clock. The memory arrays sit outside the block. The controller drives a write strobe and a data-bus output enable for ordinary accesses. For transfers it drives a request, two phase strobes and a direction flag to the array-transfer port.

A transfer starts only after a falling edge on the nonvolatile-enable pin. The requested condition must then stay on the pins for a qualification window. Once committed, the transfer runs its two timed phases without looking at the pins. During the transfer, busy is high and all accesses are blocked. A one-clock done pulse marks normal completion.

A supply-sense input does two jobs. While it is low, no STORE can start, and a STORE already running is abandoned with a one-clock aborted pulse. A RECALL ignores it. After reset the block waits with busy high until the supply is first reported good, then runs a RECALL automatically.

All durations are parameters counted in clock cycles.

Top module: `nvc_top`

## Requirements
- R1: With ceN=0, oeN=0, weN=1 and nvN=1 while idle, busOe is 1 and sramWr is 0 in the same cycle.
- R2: With ceN=0, weN=0 and nvN=1 while idle, sramWr is 1 and busOe is 0, whatever the value of oeN.
- R3: ceN=1, the combination ceN=0/oeN=1/weN=1/nvN=1, and all four pins low each give busOe=0 and sramWr=0, and none of them starts a transfer.
- R4: A transfer is committed only after nvN has gone from 1 to 0 while idle. Keeping the STORE pins (ceN=0, weN=0, nvN=0, oeN=1) held after a transfer ends starts no second transfer. Holding nvN low through reset and power-up starts no STORE.
- R5: A STORE or RECALL condition commits only if it is present at INIT_CYC+1 consecutive rising clock edges, counting from the edge that first sees it with the nvN fall registered. If the condition is held for only INIT_CYC edges, nothing starts.
- R6: A STORE drives phaseWipe for ERASE_CYC cycles and then phaseFill for PROG_CYC cycles, with xferStore=1 and xferReq high in both phases. busy is high for exactly those cycles. done is high for the single cycle in which busy first reads 0.
- R7: A RECALL (ceN=0, oeN=0, nvN=0, weN=1) drives phaseWipe for CLR_CYC cycles and then phaseFill for COPY_CYC cycles, with xferStore=0.
- R8: While busy is high, busOe and sramWr stay 0, and pin changes alter neither the length of the transfer nor its direction.
- R9: While supplyOk is 0, no STORE starts. If supplyOk reads 0 during a STORE, busy falls at the next edge, aborted pulses for one cycle and done stays 0.
- R10: supplyOk going low during a RECALL does not shorten it, and the RECALL ends with done and without aborted.
- R11: After reset, busy is 1 and no access is made until supplyOk is first 1. A RECALL of CLR_CYC+COPY_CYC cycles then follows. A later return of the supply starts no further RECALL.
- R12: If the read pins are present when a transfer ends, busOe is 1 in the same cycle that done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| nvN | input | 1 | Nonvolatile enable, active low |
| supplyOk | input | 1 | Supply above threshold |
| sramWr | output | 1 | SRAM write strobe |
| busOe | output | 1 | Data-bus output enable (SRAM read) |
| busy | output | 1 | Power-up wait or transfer in progress |
| xferReq | output | 1 | Array transfer request |
| phaseWipe | output | 1 | First phase: erase (STORE) or clear (RECALL) |
| phaseFill | output | 1 | Second phase: program (STORE) or copy (RECALL) |
| xferStore | output | 1 | Transfer direction, 1 = STORE, gated by xferReq |
| done | output | 1 | One-cycle pulse on normal completion |
| aborted | output | 1 | One-cycle pulse when a STORE is abandoned |

## Verification
The assertions assume the pins and supplyOk are synchronous, single-valued signals that change only between clock edges. They also assume supplyOk stays low through reset, so that the power-up RECALL is the first transfer seen. The bench drives every input on the falling edge and keeps supplyOk low until reset has been released. It restores supplyOk only after an abort or a RECALL has finished, which keeps each transfer the assertions watch inside those assumptions.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [2:0] {
    MODE_DESEL,
    MODE_READ,
    MODE_WRITE,
    MODE_RECALL,
    MODE_STORE,
    MODE_NOP
  } nvMode_t;

  // counter load selector
  typedef enum logic [1:0] {
    LD_QUAL,
    LD_PH1,
    LD_PH2
  } cntSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    cntLoad;
    cntSel_t cntSel;
    logic    cntDec;
    logic    setDir;
    logic    dirStore;
    logic    clrArm;
    logic    armHold;
    logic    pulseDone;
    logic    pulseAbort;
  } nvStrobe_t;

endpackage

// File: rtl/nvc_datapath.sv
module nvc_datapath
  import nvc_pkg::*;
#(
  parameter int INIT_CYC  = 3,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 5,
  parameter int CLR_CYC   = 3,
  parameter int COPY_CYC  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceN,
  input  logic      oeN,
  input  logic      weN,
  input  logic      nvN,
  input  nvStrobe_t strb,
  output nvMode_t   mode,
  output logic      armedNow,
  output logic      cntZero,
  output logic      dirStore,
  output logic      done,
  output logic      aborted
);

  localparam int MAXA = (INIT_CYC > ERASE_CYC) ? INIT_CYC : ERASE_CYC;
  localparam int MAXB = (PROG_CYC > CLR_CYC) ? PROG_CYC : CLR_CYC;
  localparam int MAXC0 = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int MAXC = (MAXC0 > COPY_CYC) ? MAXC0 : COPY_CYC;
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  localparam logic [CW-1:0] L_QUAL  = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] L_ERASE = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] L_PROG  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] L_CLR   = CW'(CLR_CYC - 1);
  localparam logic [CW-1:0] L_COPY  = CW'(COPY_CYC - 1);

  logic          nvPrev;
  logic          armed;
  logic          nvFall;
  logic          loadDir;
  logic [CW-1:0] cnt;
  logic [CW-1:0] loadVal;

  // pin decode; nonvolatile enable takes precedence over access modes
  always_comb begin
    if (ceN) begin
      mode = MODE_DESEL;
    end else if (!nvN) begin
      if (!weN && oeN)      mode = MODE_STORE;
      else if (weN && !oeN) mode = MODE_RECALL;
      else                  mode = MODE_NOP;
    end else begin
      if (!weN)      mode = MODE_WRITE;
      else if (!oeN) mode = MODE_READ;
      else           mode = MODE_NOP;
    end
  end

  assign nvFall   = nvPrev & ~nvN;
  assign armedNow = armed | (nvFall & ~strb.armHold);
  assign cntZero  = (cnt == '0);
  assign loadDir  = strb.setDir ? strb.dirStore : dirStore;

  always_comb begin
    case (strb.cntSel)
      LD_QUAL: loadVal = L_QUAL;
      LD_PH1:  loadVal = loadDir ? L_ERASE : L_CLR;
      default: loadVal = loadDir ? L_PROG : L_COPY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvPrev   <= 1'b0;   // no edge can be seen from a pin held low at reset
      armed    <= 1'b0;
      dirStore <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
      aborted  <= 1'b0;
    end else begin
      nvPrev <= nvN;
      if (strb.clrArm || nvN) armed <= 1'b0;
      else if (nvFall && !strb.armHold) armed <= 1'b1;
      if (strb.setDir) dirStore <= strb.dirStore;
      if (strb.cntLoad) cnt <= loadVal;
      else if (strb.cntDec) cnt <= cnt - 1'b1;
      done    <= strb.pulseDone;
      aborted <= strb.pulseAbort;
    end
  end

endmodule

// File: rtl/nvc_ctrl.sv
module nvc_ctrl
  import nvc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  nvMode_t   mode,
  input  logic      armedNow,
  input  logic      cntZero,
  input  logic      dirStore,
  input  logic      supplyOk,
  output nvStrobe_t strb,
  output logic      busy,
  output logic      phaseWipe,
  output logic      phaseFill
);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_QUAL, S_PH1, S_PH2} state_t;

  state_t state, stateNext;
  logic   wantStore, wantRecall, holding;

  assign wantStore  = (mode == MODE_STORE) && supplyOk;
  assign wantRecall = (mode == MODE_RECALL);
  assign holding    = dirStore ? wantStore : wantRecall;

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.cntSel = LD_QUAL;
    case (state)
      S_PWR: begin
        strb.armHold = 1'b1;
        if (supplyOk) begin
          stateNext     = S_PH1;
          strb.setDir   = 1'b1;
          strb.dirStore = 1'b0;
          strb.cntLoad  = 1'b1;
          strb.cntSel   = LD_PH1;
        end
      end
      S_IDLE: begin
        if (armedNow && (wantStore || wantRecall)) begin
          stateNext     = S_QUAL;
          strb.setDir   = 1'b1;
          strb.dirStore = wantStore;
          strb.cntLoad  = 1'b1;
          strb.cntSel   = LD_QUAL;
        end
      end
      S_QUAL: begin
        if (!holding) begin
          stateNext = S_IDLE;
        end else if (cntZero) begin
          stateNext    = S_PH1;
          strb.clrArm  = 1'b1;
          strb.cntLoad = 1'b1;
          strb.cntSel  = LD_PH1;
        end else begin
          strb.cntDec = 1'b1;
        end
      end
      S_PH1: begin
        strb.armHold = 1'b1;
        if (dirStore && !supplyOk) begin
          stateNext       = S_IDLE;
          strb.pulseAbort = 1'b1;
        end else if (cntZero) begin
          stateNext    = S_PH2;
          strb.cntLoad = 1'b1;
          strb.cntSel  = LD_PH2;
        end else begin
          strb.cntDec = 1'b1;
        end
      end
      default: begin
        strb.armHold = 1'b1;
        if (dirStore && !supplyOk) begin
          stateNext       = S_IDLE;
          strb.pulseAbort = 1'b1;
        end else if (cntZero) begin
          stateNext      = S_IDLE;
          strb.pulseDone = 1'b1;
        end else begin
          strb.cntDec = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_PWR;
    else       state <= stateNext;
  end

  assign busy      = (state == S_PWR) || (state == S_PH1) || (state == S_PH2);
  assign phaseWipe = (state == S_PH1);
  assign phaseFill = (state == S_PH2);

endmodule

// File: rtl/nvc_top.sv
module nvc_top
  import nvc_pkg::*;
#(
  parameter int INIT_CYC  = 3,
  parameter int ERASE_CYC = 6,
  parameter int PROG_CYC  = 5,
  parameter int CLR_CYC   = 3,
  parameter int COPY_CYC  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  input  logic nvN,
  input  logic supplyOk,
  output logic sramWr,
  output logic busOe,
  output logic busy,
  output logic xferReq,
  output logic phaseWipe,
  output logic phaseFill,
  output logic xferStore,
  output logic done,
  output logic aborted
);

  nvMode_t   mode;
  nvStrobe_t strb;
  logic      armedNow, cntZero, dirStore;

  nvc_datapath #(
    .INIT_CYC(INIT_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .CLR_CYC(CLR_CYC), .COPY_CYC(COPY_CYC)
  ) uData (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .nvN(nvN),
    .strb(strb), .mode(mode), .armedNow(armedNow), .cntZero(cntZero),
    .dirStore(dirStore), .done(done), .aborted(aborted)
  );

  nvc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .mode(mode), .armedNow(armedNow),
    .cntZero(cntZero), .dirStore(dirStore), .supplyOk(supplyOk),
    .strb(strb), .busy(busy), .phaseWipe(phaseWipe), .phaseFill(phaseFill)
  );

  assign busOe     = !busy && (mode == MODE_READ);
  assign sramWr    = !busy && (mode == MODE_WRITE);
  assign xferReq   = phaseWipe | phaseFill;
  assign xferStore = dirStore & xferReq;

endmodule

// File: rtl/nvc_chk.sv
module nvc_chk (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic sramWr,
  input logic busOe,
  input logic busy,
  input logic xferReq,
  input logic phaseWipe,
  input logic phaseFill,
  input logic xferStore,
  input logic done,
  input logic aborted
);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!busOe && !sramWr));

  // R6
  xfer_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> (busy && $onehot0({phaseWipe, phaseFill})));

  // R6
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseFill) |-> $past(phaseWipe));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !aborted) ##1 !done);

  // R9
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    aborted |-> ($past(xferStore) && !$past(supplyOk) && !busy));

  // R9
  store_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(phaseWipe) && xferStore) |-> $past(supplyOk));

  // R10
  recall_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(phaseWipe) && $past(xferReq) && !$past(xferStore)) |-> phaseFill);

endmodule

bind nvc_top nvc_chk uChk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .sramWr(sramWr),
  .busOe(busOe), .busy(busy), .xferReq(xferReq), .phaseWipe(phaseWipe),
  .phaseFill(phaseFill), .xferStore(xferStore), .done(done), .aborted(aborted)
);

// File: tb/tb_nvc_top.sv
module tb_nvc_top;

  localparam int INIT_CYC  = 3;
  localparam int ERASE_CYC = 6;
  localparam int PROG_CYC  = 5;
  localparam int CLR_CYC   = 3;
  localparam int COPY_CYC  = 4;

  logic clk = 1'b0;
  logic rstN, ceN, oeN, weN, nvN, supplyOk;
  logic sramWr, busOe, busy, xferReq, phaseWipe, phaseFill, xferStore, done, aborted;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nvc_top #(
    .INIT_CYC(INIT_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .CLR_CYC(CLR_CYC), .COPY_CYC(COPY_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .nvN(nvN),
    .supplyOk(supplyOk), .sramWr(sramWr), .busOe(busOe), .busy(busy),
    .xferReq(xferReq), .phaseWipe(phaseWipe), .phaseFill(phaseFill),
    .xferStore(xferStore), .done(done), .aborted(aborted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setPins(input bit c, input bit o, input bit w, input bit n);
    ceN = c; oeN = o; weN = w; nvN = n;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for busy, then samples every busy cycle
  task automatic measure(input int readAt, input int dropAt,
                         output int bc, output int ac, output int fc,
                         output int dirOnes, output int leak,
                         output bit dn, output bit ab, output bit oe);
    int waitN;
    waitN = 0; bc = 0; ac = 0; fc = 0; dirOnes = 0; leak = 0;
    @(negedge clk);
    while (!busy && waitN < 30) begin
      waitN++;
      @(negedge clk);
    end
    while (busy && bc < 1000) begin
      bc++;
      if (phaseWipe) ac++;
      if (phaseFill) fc++;
      if (xferStore) dirOnes++;
      if (busOe || sramWr) leak++;
      if (bc == readAt) setPins(0, 0, 1, 1);
      if (bc == dropAt) supplyOk = 1'b0;
      @(negedge clk);
    end
    dn = done; ab = aborted; oe = busOe;
  endtask

  task automatic quietFor(input int n, input string req);
    int seen;
    seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic armStore();
    setPins(0, 1, 1, 1); tick(1);
    setPins(0, 1, 1, 0); tick(1);
    setPins(0, 1, 0, 0);
  endtask

  task automatic armRecall();
    setPins(0, 0, 1, 1); tick(1);
    setPins(0, 0, 1, 0);
  endtask

  task automatic testPowerUp();
    int bc, ac, fc, d1, lk; bit dn, ab, oe;
    rstN = 1'b0; supplyOk = 1'b0; setPins(1, 1, 1, 1);
    tick(3);
    rstN = 1'b1;
    setPins(0, 0, 1, 1);
    tick(2);
    chk(busy == 1'b1, "R11 busy before supply", busy, 1);
    chk(busOe == 1'b0, "R11 read blocked before supply", busOe, 0);
    supplyOk = 1'b1;
    measure(-1, -1, bc, ac, fc, d1, lk, dn, ab, oe);
    chk(bc == CLR_CYC + COPY_CYC, "R11 power-up recall length", bc, CLR_CYC + COPY_CYC);
    chk(ac == CLR_CYC && fc == COPY_CYC, "R7 recall phase split", ac * 100 + fc, CLR_CYC * 100 + COPY_CYC);
    chk(d1 == 0, "R7 recall direction", d1, 0);
    chk(dn == 1'b1, "R6 done after power-up recall", dn, 1);
    chk(oe == 1'b1, "R12 read at end of power-up recall", oe, 1);
    tick(1);
    chk(done == 1'b0, "R6 done is one cycle", done, 0);
  endtask

  task automatic testDecode();
    setPins(0, 0, 1, 1); tick(1);
    chk(busOe == 1'b1 && sramWr == 1'b0, "R1 read decode", {busOe, sramWr}, 2);
    setPins(0, 1, 0, 1); tick(1);
    chk(sramWr == 1'b1 && busOe == 1'b0, "R2 write decode oe high", {sramWr, busOe}, 2);
    setPins(0, 0, 0, 1); tick(1);
    chk(sramWr == 1'b1 && busOe == 1'b0, "R2 write decode oe low", {sramWr, busOe}, 2);
    setPins(1, 0, 0, 1); tick(1);
    chk(!sramWr && !busOe, "R3 deselected", {sramWr, busOe}, 0);
    setPins(0, 1, 1, 1); tick(1);
    chk(!sramWr && !busOe, "R3 no access with oe and we high", {sramWr, busOe}, 0);
    setPins(0, 0, 0, 0); tick(1);
    chk(!sramWr && !busOe, "R3 all pins low", {sramWr, busOe}, 0);
    quietFor(12, "R3 all pins low starts nothing");
    setPins(1, 1, 1, 1); tick(1);
  endtask

  task automatic testStore();
    int bc, ac, fc, d1, lk; bit dn, ab, oe;
    armStore();
    measure(2, -1, bc, ac, fc, d1, lk, dn, ab, oe);
    chk(bc == ERASE_CYC + PROG_CYC, "R6 store length", bc, ERASE_CYC + PROG_CYC);
    chk(ac == ERASE_CYC && fc == PROG_CYC, "R6 store phase split", ac * 100 + fc, ERASE_CYC * 100 + PROG_CYC);
    chk(d1 == bc, "R6 store direction", d1, bc);
    chk(lk == 0, "R8 no access while busy", lk, 0);
    chk(dn == 1'b1 && ab == 1'b0, "R6 store done", {dn, ab}, 2);
    chk(oe == 1'b1, "R12 read at end of store", oe, 1);
  endtask

  task automatic testNoRetrigger();
    int bc, ac, fc, d1, lk; bit dn, ab, oe;
    armStore();
    measure(-1, -1, bc, ac, fc, d1, lk, dn, ab, oe);
    chk(bc == ERASE_CYC + PROG_CYC, "R4 store before hold", bc, ERASE_CYC + PROG_CYC);
    chk(oe == 1'b0, "R12 no output when pins not read", oe, 0);
    quietFor(25, "R4 held store pins do not retrigger");
    setPins(1, 1, 1, 1); tick(1);
  endtask

  task automatic testInitWindow();
    int bc, ac, fc, d1, lk; bit dn, ab, oe;
    armRecall();
    tick(INIT_CYC);
    setPins(0, 0, 1, 1);
    quietFor(10, "R5 short initiation ignored");
    armRecall();
    measure(1, -1, bc, ac, fc, d1, lk, dn, ab, oe);
    chk(bc == CLR_CYC + COPY_CYC, "R5 full initiation commits recall", bc, CLR_CYC + COPY_CYC);
    chk(d1 == 0, "R7 pin recall direction", d1, 0);
    chk(dn == 1'b1 && oe == 1'b1, "R12 done with output enable", {dn, oe}, 3);
  endtask

  task automatic testAbort();
    int bc, ac, fc, d1, lk; bit dn, ab, oe;
    armStore();
    measure(-1, 3, bc, ac, fc, d1, lk, dn, ab, oe);
    chk(bc == 3, "R9 store abandoned at low supply", bc, 3);
    chk(ab == 1'b1 && dn == 1'b0, "R9 aborted not done", {ab, dn}, 2);
    tick(1);
    chk(aborted == 1'b0, "R9 aborted is one cycle", aborted, 0);
    supplyOk = 1'b1;
    quietFor(20, "R11 supply return starts no recall");
    setPins(1, 1, 1, 1); tick(1);
    supplyOk = 1'b0;
    armStore();
    quietFor(20, "R9 store not started on low supply");
    setPins(1, 1, 1, 1); tick(1);
  endtask

  task automatic testRecallLowSupply();
    int bc, ac, fc, d1, lk; bit dn, ab, oe;
    supplyOk = 1'b1;
    armRecall();
    measure(-1, 2, bc, ac, fc, d1, lk, dn, ab, oe);
    chk(bc == CLR_CYC + COPY_CYC, "R10 recall length under low supply", bc, CLR_CYC + COPY_CYC);
    chk(dn == 1'b1 && ab == 1'b0, "R10 recall done not aborted", {dn, ab}, 2);
    supplyOk = 1'b1;
    setPins(1, 1, 1, 1); tick(1);
  endtask

  task automatic testHeldLowPowerUp();
    int bc, ac, fc, d1, lk; bit dn, ab, oe;
    rstN = 1'b0; supplyOk = 1'b0; setPins(0, 1, 0, 0);
    tick(3);
    rstN = 1'b1;
    tick(2);
    supplyOk = 1'b1;
    measure(-1, -1, bc, ac, fc, d1, lk, dn, ab, oe);
    chk(bc == CLR_CYC + COPY_CYC && d1 == 0, "R11 recall with nv low at power-up", bc, CLR_CYC + COPY_CYC);
    quietFor(25, "R4 nv low at power-up starts no store");
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    testPowerUp();
    testDecode();
    testStore();
    testNoRetrigger();
    testInitWindow();
    testAbort();
    testRecallLowSupply();
    testHeldLowPowerUp();
    finishRun();
  end

endmodule